// File: doc/BRIEF.md
# Completion Entry Poster

This block turns finished-command reports into 16-byte completion records and stores them, one after another, into a circular completion ring that lives in host memory. Each report carries five values: the command identifier, the submission queue identifier, the submission head snapshot, a 15-bit status and one 32-bit result dword. The block packs these with the current phase tag and emits the record as four 32-bit write beats on a simple valid/ready write-request port. The address of the record is the ring base plus the slot index times 16.

The block keeps the ring state: the producer slot index (tail), the host's consumer index (head, taken from doorbell writes) and the phase tag. The phase tag inverts each time the tail wraps past the last slot. This lets the host find fresh records by comparing phase bits, without reading a tail register. While the ring holds records that the host has not yet released through the doorbell, an interrupt request stays high. A ring setup pulse loads a new base and size and restarts the ring state. When the ring is full, the block stops accepting reports.

Top module: `cq_poster`

## Requirements
- R1: After reset, and in the cycle after a `ring_init` pulse, the tail and head are 0 and the phase is 1. `irq` and `wr_valid` are low, and `cpl_ready` is high whenever the ring has more than one slot.
- R2: A record holds the following fields. Bits 31:0 are the result dword and bits 63:32 are zero. Bits 79:64 are the submission head snapshot and bits 95:80 are the submission queue id. Bits 111:96 are the command id, bit 112 is the phase tag and bits 127:113 are the status.
- R3: A record is written as exactly four beats, least significant dword first. Beat k goes to address base + 16*tail + 4*k, and `wr_valid` is high only while a record is being written.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values.
- R5: The tail advances by one only when the fourth beat is accepted. After slot `ring_size_m1` it wraps to slot 0.
- R6: Records written on the first pass after setup carry phase 1. The phase inverts on every wrap of the tail.
- R7: `cpl_ready` is low while a record is being written, and whenever (tail+1) modulo (ring_size_m1+1) equals the head (ring full).
- R8: `irq` is high exactly when tail differs from head. A `db_valid` pulse sets the head to `db_head` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_init | input | 1 | Pulse: load ring base and size, restart ring state |
| ring_base | input | ADDR_W | Byte address of slot 0 (16-byte aligned) |
| ring_size_m1 | input | IDX_W | Number of slots minus one |
| cpl_valid | input | 1 | Completion report present |
| cpl_ready | output | 1 | Report accepted when high together with cpl_valid |
| cpl_cid | input | 16 | Command identifier |
| cpl_sqid | input | 16 | Submission queue identifier |
| cpl_sqhd | input | 16 | Submission head snapshot |
| cpl_status | input | 15 | Status, zero for success |
| cpl_result | input | 32 | Command-specific result dword |
| db_valid | input | 1 | Host head doorbell write |
| db_head | input | IDX_W | New head index from the host |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | 32 | Beat data |
| irq | output | 1 | Unconsumed records exist |

## Verification
A corrupted tail shows on `wr_addr` at the first beat of the next record. It also shows on `irq` and `cpl_ready` in the cycle after the corrupting edge, because both are compared against a head that the bench tracks itself. A phase that flips at the wrong time shows on bit 16 of the fourth beat of the next record. A beat counter that skips or repeats shows as a wrong address or dword on the very next accepted beat. Stalls on `wr_ready` are random, so a value that drifts during a stall is caught on the cycle it moves.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    localparam int DW       = 32;
    localparam int BEATS    = 4;
    localparam int BEAT_W   = $clog2(BEATS);
    localparam int SLOT_SH  = $clog2(BEATS * DW / 8);

    typedef struct packed {
        logic [14:0] status;
        logic        phase;
        logic [15:0] cid;
        logic [15:0] sqid;
        logic [15:0] sqhd;
        logic [31:0] rsvd;
        logic [31:0] result;
    } cq_rec_t;

    function automatic cq_rec_t pack_rec(
        input logic [15:0] cid,
        input logic [15:0] sqid,
        input logic [15:0] sqhd,
        input logic [14:0] status,
        input logic [31:0] result,
        input logic        phase
    );
        cq_rec_t r;
        r.status = status;
        r.phase  = phase;
        r.cid    = cid;
        r.sqid   = sqid;
        r.sqhd   = sqhd;
        r.rsvd   = '0;
        r.result = result;
        return r;
    endfunction

endpackage

// File: rtl/cqp_ring.sv
module cqp_ring
    import cqp_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int IDX_W       = 16,
    parameter int RST_SIZE_M1 = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [ADDR_W-1:0] init_base,
    input  logic [IDX_W-1:0]  init_size_m1,
    input  logic              advance,
    input  logic              db_valid,
    input  logic [IDX_W-1:0]  db_head,
    output logic              phase,
    output logic              full,
    output logic              pending,
    output logic [ADDR_W-1:0] slot_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  size_m1;
        logic [IDX_W-1:0]  tail;
        logic [IDX_W-1:0]  head;
        logic              phase;
    } ring_t;

    ring_t st_q, st_d;
    logic [IDX_W-1:0] nxt_tail;
    logic             at_end;

    always_comb begin
        at_end   = (st_q.tail == st_q.size_m1);
        nxt_tail = at_end ? '0 : IDX_W'(st_q.tail + 1'b1);
        st_d     = st_q;
        if (init) begin
            st_d.base    = init_base;
            st_d.size_m1 = init_size_m1;
            st_d.tail    = '0;
            st_d.head    = '0;
            st_d.phase   = 1'b1;
        end else begin
            if (advance) begin
                st_d.tail  = nxt_tail;
                st_d.phase = st_q.phase ^ at_end;
            end
            if (db_valid) begin
                st_d.head = db_head;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base    <= '0;
            st_q.size_m1 <= IDX_W'(RST_SIZE_M1);
            st_q.tail    <= '0;
            st_q.head    <= '0;
            st_q.phase   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign full      = (nxt_tail == st_q.head);
    assign pending   = (st_q.tail != st_q.head);
    assign slot_addr = st_q.base + ADDR_W'({st_q.tail, {SLOT_SH{1'b0}}});

    // R5
    wrap_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !init && at_end) |=> (st_q.tail == '0));

    // R6
    wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !init && at_end) |=> (st_q.phase != $past(st_q.phase)));

    // R6
    no_wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !(advance && at_end)) |=> $stable(st_q.phase));

endmodule

// File: rtl/cqp_beat.sv
module cqp_beat
    import cqp_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              full,
    input  logic              cpl_valid,
    input  cq_rec_t           rec,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic              cpl_ready,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              done
);

    typedef struct packed {
        logic              busy;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] addr;
        cq_rec_t           rec;
    } seq_t;

    seq_t st_q, st_d;
    logic [BEATS-1:0][DW-1:0] dwords;
    logic last;

    assign dwords = st_q.rec;

    always_comb begin
        cpl_ready = !st_q.busy && !full;
        last      = (st_q.beat == BEAT_W'(BEATS - 1));
        done      = st_q.busy && wr_ready && last;
        st_d      = st_q;
        if (flush) begin
            st_d.busy = 1'b0;
            st_d.beat = '0;
        end else if (st_q.busy) begin
            if (wr_ready) begin
                st_d.beat = BEAT_W'(st_q.beat + 1'b1);
                if (last) begin
                    st_d.busy = 1'b0;
                end
            end
        end else if (cpl_valid && cpl_ready) begin
            st_d.busy = 1'b1;
            st_d.beat = '0;
            st_d.addr = slot_addr;
            st_d.rec  = rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.beat <= '0;
            st_q.addr <= '0;
            st_q.rec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.busy;
    assign wr_addr  = st_q.addr + ADDR_W'({st_q.beat, 2'b00});
    assign wr_data  = dwords[st_q.beat];

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (wr_valid && wr_ready && !last) |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(4)));

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cpl_ready);

endmodule

// File: rtl/cq_poster.sv
module cq_poster
    import cqp_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int IDX_W       = 16,
    parameter int RST_SIZE_M1 = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_init,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_size_m1,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [15:0]       cpl_cid,
    input  logic [15:0]       cpl_sqid,
    input  logic [15:0]       cpl_sqhd,
    input  logic [14:0]       cpl_status,
    input  logic [31:0]       cpl_result,
    input  logic              db_valid,
    input  logic [IDX_W-1:0]  db_head,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              irq
);

    logic              phase, full, pending, done;
    logic [ADDR_W-1:0] slot_addr;
    cq_rec_t           rec;

    assign rec = pack_rec(cpl_cid, cpl_sqid, cpl_sqhd, cpl_status, cpl_result, phase);

    cqp_ring #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .RST_SIZE_M1 (RST_SIZE_M1)
    ) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .init         (ring_init),
        .init_base    (ring_base),
        .init_size_m1 (ring_size_m1),
        .advance      (done),
        .db_valid     (db_valid),
        .db_head      (db_head),
        .phase        (phase),
        .full         (full),
        .pending      (pending),
        .slot_addr    (slot_addr)
    );

    cqp_beat #(
        .ADDR_W (ADDR_W)
    ) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ring_init),
        .full      (full),
        .cpl_valid (cpl_valid),
        .rec       (rec),
        .slot_addr (slot_addr),
        .cpl_ready (cpl_ready),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done)
    );

    assign irq = pending;

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !cpl_ready);

    // R8
    post_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !db_valid && !ring_init) |=> irq);

    // R1
    init_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_init |=> (!irq && !wr_valid));

endmodule

// File: tb/cq_poster_bench.sv
`timescale 1ns/1ps
module cq_poster_bench;

    localparam int AW = 64;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ring_init = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [IW-1:0] ring_size_m1 = '0;
    logic          cpl_valid = 1'b0;
    logic          cpl_ready;
    logic [15:0]   cpl_cid = '0, cpl_sqid = '0, cpl_sqhd = '0;
    logic [14:0]   cpl_status = '0;
    logic [31:0]   cpl_result = '0;
    logic          db_valid = 1'b0;
    logic [IW-1:0] db_head = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          irq;

    always #2 clk = ~clk;

    cq_poster u_cq_poster (
        .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .ring_base(ring_base),
        .ring_size_m1(ring_size_m1), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_cid(cpl_cid), .cpl_sqid(cpl_sqid), .cpl_sqhd(cpl_sqhd),
        .cpl_status(cpl_status), .cpl_result(cpl_result), .db_valid(db_valid),
        .db_head(db_head), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    logic [AW-1:0]  m_base;
    int             m_n, m_tail, m_head, m_beat;
    bit             m_phase, m_busy, m_stall;
    logic [AW-1:0]  m_addr;
    logic [127:0]   m_ent;

    function automatic logic [127:0] exp_rec(input logic [15:0] cid, input logic [15:0] sqid,
                                             input logic [15:0] sqhd, input logic [14:0] st,
                                             input logic [31:0] res, input bit ph);
        logic [127:0] e;
        e = '0;
        e[31:0]    = res;
        e[79:64]   = sqhd;
        e[95:80]   = sqid;
        e[111:96]  = cid;
        e[112]     = ph;
        e[127:113] = st;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int cpl_pct, input int rdy_pct, input int db_pct);
        bit exp_ready, cv, wr, dv;
        int pend, dh;
        logic [15:0] c, s, h;
        logic [14:0] st;
        logic [31:0] res;
        exp_ready = !m_busy && (((m_tail + 1) % m_n) != m_head);
        chk(cpl_ready == exp_ready, "R7 cpl_ready", 64'(cpl_ready), 64'(exp_ready));
        chk(irq == (m_tail != m_head), "R8 irq", 64'(irq), 64'(m_tail != m_head));
        chk(wr_valid == m_busy, "R3 wr_valid", 64'(wr_valid), 64'(m_busy));
        if (m_busy && wr_valid) begin
            if (m_stall)
                chk(wr_addr == m_addr + AW'(4 * m_beat), "R4 held addr", wr_addr, m_addr + AW'(4 * m_beat));
            chk(wr_addr == m_addr + AW'(4 * m_beat), "R3 R5 beat addr", wr_addr, m_addr + AW'(4 * m_beat));
            chk(wr_data == m_ent[32*m_beat +: 32], "R2 beat data", 64'(wr_data), 64'(m_ent[32*m_beat +: 32]));
            if (m_beat == 3)
                chk(wr_data[16] == m_ent[112], "R6 phase", 64'(wr_data[16]), 64'(m_ent[112]));
        end
        cv  = ($urandom % 100) < cpl_pct;
        wr  = ($urandom % 100) < rdy_pct;
        c = 16'($urandom); s = 16'($urandom); h = 16'($urandom);
        st = ($urandom % 4 == 0) ? 15'($urandom) : 15'd0;
        res = $urandom;
        pend = (m_tail - m_head + m_n) % m_n;
        dv = (pend > 0) && (($urandom % 100) < db_pct);
        dh = dv ? (m_head + 1 + int'($urandom % pend)) % m_n : 0;
        cpl_valid = cv; cpl_cid = c; cpl_sqid = s; cpl_sqhd = h;
        cpl_status = st; cpl_result = res; wr_ready = wr;
        db_valid = dv; db_head = IW'(dh);
        m_stall = m_busy && !wr;
        if (m_busy && wr) begin
            if (m_beat == 3) begin
                m_busy = 0;
                if (m_tail == m_n - 1) begin
                    m_tail = 0;
                    m_phase = !m_phase;
                end else begin
                    m_tail++;
                end
            end else begin
                m_beat++;
            end
        end else if (cv && exp_ready) begin
            m_busy = 1;
            m_beat = 0;
            m_addr = m_base + AW'(m_tail) * 16;
            m_ent  = exp_rec(c, s, h, st, res, m_phase);
        end
        if (dv) m_head = dh;
        @(negedge clk);
    endtask

    task automatic setup(input logic [AW-1:0] base, input int n);
        cpl_valid = 0; db_valid = 0; wr_ready = 0;
        ring_init = 1; ring_base = base; ring_size_m1 = IW'(n - 1);
        @(negedge clk);
        ring_init = 0;
        m_base = base; m_n = n; m_tail = 0; m_head = 0;
        m_phase = 1; m_busy = 0; m_stall = 0; m_beat = 0;
        chk(irq == 0, "R1 irq after setup", 64'(irq), 0);
        chk(wr_valid == 0, "R1 wr_valid after setup", 64'(wr_valid), 0);
        chk(cpl_ready == (n > 1), "R1 cpl_ready after setup", 64'(cpl_ready), 64'(n > 1));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(irq == 0, "R1 irq after reset", 64'(irq), 0);
        chk(wr_valid == 0, "R1 wr_valid after reset", 64'(wr_valid), 0);
        chk(cpl_ready == 1, "R1 cpl_ready after reset", 64'(cpl_ready), 1);

        // Four-slot ring: fill until full, no doorbell, fast memory
        setup(64'h0000_0001_0000_1000, 4);
        repeat (40) tick(100, 100, 0);
        // R7 ring full: three records posted
        chk(cpl_ready == 0 && irq == 1, "R7 full stall", {cpl_ready, irq}, 2'b01);
        // Release all, then wrap twice with slow memory (R6 phase flips)
        repeat (400) tick(80, 30, 40);
        // Back-to-back with a stalled memory
        repeat (200) tick(100, 10, 30);

        // Larger ring, random mix, then re-setup mid-stream
        setup(64'h0000_0000_8000_0000 | 64'({$urandom} & 32'hFFF0), 8);
        repeat (3000) tick(60, 50, 20);
        tick(100, 0, 0);
        setup(64'h0000_0002_0000_0040, 2);
        repeat (300) tick(70, 60, 50);
        setup(64'h0000_0000_0000_0000, 32);
        repeat (4000) tick(50, 70, 10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule